// File: doc/BRIEF.md
# Serial Channel Loopback and Modem Flow Gate

This block sits between one channel's serial transmitter/receiver core and that channel's line and modem pins. It steers the serial bit streams along one of three routes: straight through, an internal local loop, or a remote echo. Three small state machines decide the route, drive the request-to-send line, and produce the two qualifiers that the core obeys. The transmit-permit qualifier tells the transmitter whether it may begin a new character. The receive-discard qualifier tells the receiver to drop what it assembles. Baud timing and character framing stay in the core.

The route machine has three states. In RT_NORMAL the core's serial output goes to the line and the line input goes to the core. In RT_LOCAL the line output idles at the marking level and the core's own output feeds its receiver. In RT_REMOTE the line input is echoed back out on the line output. On every clock the machine moves to RT_LOCAL if the local-loop bit is set. Otherwise it moves to RT_REMOTE if the remote-loop bit is set, and to RT_NORMAL if neither bit is set.

The request-to-send machine moves between RTS_OFF and RTS_ON. In automatic mode it enters RTS_ON while the channel is enabled and any transmit stage holds data, and it returns to RTS_OFF otherwise. In manual mode it follows a level bit. Two gate machines, one for clear-to-send and one for data-set-ready, move between GT_PASS and GT_BLOCK. Each enters GT_BLOCK while its enable bit is set and its synchronized active-low pin is high, and returns to GT_PASS otherwise. The modem pins are all active-low.

Top module: `serial_loop_flow`

## Requirements
- R1: While rst_n is low: rts_n is 1, tx_permit is 1, rx_discard is 0, and the route is RT_NORMAL (txd_pin equals txd_core).
- R2: With both loop bits clear, txd_pin follows txd_core and rxd_core follows rxd_pin.
- R3: With loc_loop_en set, txd_pin is 1 and rxd_core equals txd_core. Activity on rxd_pin changes neither output.
- R4: With rem_loop_en set and loc_loop_en clear, txd_pin equals rxd_pin and rxd_core equals rxd_pin. Activity on txd_core does not reach txd_pin.
- R5: With both loop bits set, the block behaves as in R3 (the local loop takes priority).
- R6: A change of the loop bits takes effect on the first rising clock edge after the change, and not before it.
- R7: With auto_rts_en set, rts_n is 0 one clock after chan_en is 1 and any bit of tx_busy is 1. tx_busy bit 2 is the FIFO, bit 1 the holding register and bit 0 the shift register.
- R8: With auto_rts_en set, rts_n is 1 one clock after chan_en is 0, or after all tx_busy bits are 0.
- R9: With auto_rts_en clear, rts_n is the inverse of rts_manual, delayed by one clock, whatever chan_en and tx_busy hold.
- R10: tx_permit is 0 when cts_gate_en is set and the synchronized cts_n is 1. Otherwise tx_permit is 1.
- R11: rx_discard is 1 when dsr_gate_en is set and the synchronized dsr_n is 1. Otherwise rx_discard is 0.
- R12: A change on cts_n or dsr_n shows at its qualifier on the third rising edge after it (two synchronizer stages plus the gate state). A change of a gate enable bit shows on the first rising edge.
- R13: Deasserting CTS touches only tx_permit. A character in progress keeps flowing from txd_core to txd_pin bit by bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_en | input | 1 | Channel enabled |
| loc_loop_en | input | 1 | Select local loop route |
| rem_loop_en | input | 1 | Select remote echo route |
| auto_rts_en | input | 1 | RTS driven from channel enable and transmit occupancy |
| rts_manual | input | 1 | RTS level used when automatic mode is off (1 = assert) |
| cts_gate_en | input | 1 | Let CTS gate the start of transmission |
| dsr_gate_en | input | 1 | Let DSR gate reception |
| tx_busy | input | BUSY_W | Transmit occupancy flags (FIFO, holding, shift) |
| txd_core | input | 1 | Serial output of the transmitter core |
| rxd_core | output | 1 | Serial input delivered to the receiver core |
| txd_pin | output | 1 | Transmit data line |
| rxd_pin | input | 1 | Receive data line |
| rts_n | output | 1 | Request to send, active low |
| cts_n | input | 1 | Clear to send, active low, asynchronous |
| dsr_n | input | 1 | Data set ready, active low, asynchronous |
| tx_permit | output | 1 | Transmitter may start a new character |
| rx_discard | output | 1 | Receiver must drop characters |

## Verification
The bench builds the block with its defaults: two synchronizer stages and three occupancy flags. With these values each flag can be exercised alone, and the three-edge pin-to-qualifier delay can be tested edge by edge. A table walks the route states and the gating and RTS combinations, holding each row long enough for the slowest path to settle. Directed steps then probe the reset values, the one-edge route switch, the exact synchronizer delay, and the line bits that keep flowing while CTS is withdrawn.

// File: rtl/slf_pkg.sv
package slf_pkg;

    typedef enum logic [1:0] {
        RT_NORMAL = 2'd0,
        RT_LOCAL  = 2'd1,
        RT_REMOTE = 2'd2
    } route_e;

    typedef enum logic {
        RTS_OFF = 1'b0,
        RTS_ON  = 1'b1
    } rts_e;

    typedef enum logic {
        GT_PASS  = 1'b0,
        GT_BLOCK = 1'b1
    } gate_e;

endpackage

// File: rtl/slf_sync.sv
module slf_sync #(
    parameter int          W         = 2,
    parameter int          STAGES    = 2,
    parameter logic [W-1:0] RESET_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= RESET_VAL;
                else        chain[g] <= d_async;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= RESET_VAL;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/slf_route.sv
module slf_route
    import slf_pkg::*;
#(
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic loc_req,
    input  logic rem_req,
    input  logic txd_core,
    input  logic rxd_line,
    output logic txd_line,
    output logic rxd_core
);

    route_e state, state_nx;

    // next-route choice: local loop outranks remote echo
    always_comb begin
        if (loc_req)      state_nx = RT_LOCAL;
        else if (rem_req) state_nx = RT_REMOTE;
        else              state_nx = RT_NORMAL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RT_NORMAL;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            RT_NORMAL: begin
                txd_line = txd_core;
                rxd_core = rxd_line;
            end
            RT_LOCAL: begin
                txd_line = IDLE_LEVEL;
                rxd_core = txd_core;
            end
            RT_REMOTE: begin
                txd_line = rxd_line;
                rxd_core = rxd_line;
            end
            default: begin
                txd_line = IDLE_LEVEL;
                rxd_core = IDLE_LEVEL;
            end
        endcase
    end

    // R2: straight-through route after both loop bits clear
    assert_normal_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!loc_req && !rem_req) |=> (txd_line == txd_core && rxd_core == rxd_line));

    // R3 and R5: local loop, whatever the remote bit says
    assert_local_mark_R3: assert property (@(posedge clk) disable iff (!rst_n)
        loc_req |=> (txd_line == IDLE_LEVEL));
    assert_local_feed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        loc_req |=> (rxd_core == txd_core));

    // R4: remote echo
    assert_remote_echo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rem_req && !loc_req) |=> (txd_line == rxd_line));

endmodule

// File: rtl/slf_rts.sv
module slf_rts
    import slf_pkg::*;
#(
    parameter int BUSY_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auto_en,
    input  logic              chan_en,
    input  logic [BUSY_W-1:0] busy,
    input  logic              manual,
    output logic              rts_n
);

    rts_e state, state_nx;
    logic pending;

    assign pending = |busy;

    always_comb begin
        state_nx = state;
        unique case (state)
            RTS_OFF: begin
                if (auto_en) begin
                    if (chan_en && pending) state_nx = RTS_ON;
                end else if (manual) begin
                    state_nx = RTS_ON;
                end
            end
            RTS_ON: begin
                if (auto_en) begin
                    if (!chan_en || !pending) state_nx = RTS_OFF;
                end else if (!manual) begin
                    state_nx = RTS_OFF;
                end
            end
            default: state_nx = RTS_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RTS_OFF;
        else        state <= state_nx;
    end

    always_comb rts_n = (state != RTS_ON);

    assert_rts_assert_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && chan_en && pending) |=> !rts_n);
    assert_rts_negate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && (!chan_en || !pending)) |=> rts_n);
    assert_rts_manual_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_en) |=> (rts_n == !$past(manual)));

endmodule

// File: rtl/slf_gate.sv
module slf_gate
    import slf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gate_en,
    input  logic line_n,
    output logic blocked
);

    gate_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            GT_PASS:  if (gate_en && line_n)    state_nx = GT_BLOCK;
            GT_BLOCK: if (!gate_en || !line_n)  state_nx = GT_PASS;
            default:  state_nx = GT_PASS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= GT_PASS;
        else        state <= state_nx;
    end

    always_comb blocked = (state == GT_BLOCK);

    // R10 / R11: the qualifier follows enable and synchronized pin one edge later
    assert_gate_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && line_n) |=> blocked);
    assert_gate_open_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_en || !line_n) |=> !blocked);

endmodule

// File: rtl/serial_loop_flow.sv
module serial_loop_flow
    import slf_pkg::*;
#(
    parameter int   BUSY_W      = 3,
    parameter int   SYNC_STAGES = 2,
    parameter logic IDLE_LEVEL  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic              loc_loop_en,
    input  logic              rem_loop_en,
    input  logic              auto_rts_en,
    input  logic              rts_manual,
    input  logic              cts_gate_en,
    input  logic              dsr_gate_en,
    input  logic [BUSY_W-1:0] tx_busy,
    input  logic              txd_core,
    output logic              rxd_core,
    output logic              txd_pin,
    input  logic              rxd_pin,
    output logic              rts_n,
    input  logic              cts_n,
    input  logic              dsr_n,
    output logic              tx_permit,
    output logic              rx_discard
);

    localparam int MODEM_W = 2;
    localparam int CTS_IDX = 0;
    localparam int DSR_IDX = 1;

    logic [MODEM_W-1:0] modem_raw_n;
    logic [MODEM_W-1:0] modem_sync_n;
    logic               cts_blocked;
    logic               dsr_blocked;

    assign modem_raw_n[CTS_IDX] = cts_n;
    assign modem_raw_n[DSR_IDX] = dsr_n;

    // pins reset to the deasserted (high) level
    slf_sync #(
        .W         (MODEM_W),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL ({MODEM_W{1'b1}})
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (modem_raw_n),
        .q_sync  (modem_sync_n)
    );

    slf_route #(
        .IDLE_LEVEL (IDLE_LEVEL)
    ) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .loc_req  (loc_loop_en),
        .rem_req  (rem_loop_en),
        .txd_core (txd_core),
        .rxd_line (rxd_pin),
        .txd_line (txd_pin),
        .rxd_core (rxd_core)
    );

    slf_rts #(
        .BUSY_W (BUSY_W)
    ) u_rts (
        .clk     (clk),
        .rst_n   (rst_n),
        .auto_en (auto_rts_en),
        .chan_en (chan_en),
        .busy    (tx_busy),
        .manual  (rts_manual),
        .rts_n   (rts_n)
    );

    slf_gate u_cts_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .gate_en (cts_gate_en),
        .line_n  (modem_sync_n[CTS_IDX]),
        .blocked (cts_blocked)
    );

    slf_gate u_dsr_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .gate_en (dsr_gate_en),
        .line_n  (modem_sync_n[DSR_IDX]),
        .blocked (dsr_blocked)
    );

    assign tx_permit  = !cts_blocked;
    assign rx_discard = dsr_blocked;

    // R13: the CTS gate never alters the line route in the straight-through state
    assert_cts_route_free_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!loc_loop_en && !rem_loop_en) |=> (txd_pin == txd_core));

    // R1: qualifiers are idle while reset is held
    always_comb begin
        if (!rst_n) begin
            assert_reset_idle_R1: assert (rts_n && tx_permit && !rx_discard);
        end
    end

endmodule

// File: tb/sim_serial_loop_flow.sv
`timescale 1ns/1ps
module sim_serial_loop_flow;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chan_en = 0, loc_loop_en = 0, rem_loop_en = 0, auto_rts_en = 0;
    logic       rts_manual = 0, cts_gate_en = 0, dsr_gate_en = 0;
    logic [2:0] tx_busy = '0;
    logic       txd_core = 1'b1, rxd_pin = 1'b1, cts_n = 1'b1, dsr_n = 1'b1;
    logic       rxd_core, txd_pin, rts_n, tx_permit, rx_discard;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    serial_loop_flow u0 (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .loc_loop_en(loc_loop_en),
        .rem_loop_en(rem_loop_en), .auto_rts_en(auto_rts_en), .rts_manual(rts_manual),
        .cts_gate_en(cts_gate_en), .dsr_gate_en(dsr_gate_en), .tx_busy(tx_busy),
        .txd_core(txd_core), .rxd_core(rxd_core), .txd_pin(txd_pin), .rxd_pin(rxd_pin),
        .rts_n(rts_n), .cts_n(cts_n), .dsr_n(dsr_n), .tx_permit(tx_permit),
        .rx_discard(rx_discard)
    );

    // row: loc rem | auto | en | busy[2:0] | manual | cts_gate dsr_gate | cts_n dsr_n | txd_core rxd_pin
    //      _ expected {txd_pin, rxd_core, rts_n, tx_permit, rx_discard}
    localparam int NV = 22;
    localparam logic [18:0] VECS [NV] = '{
        19'b00_0_0_000_0_00_00_10_10110,
        19'b00_0_0_000_0_00_00_01_01110,
        19'b10_0_0_000_0_00_00_01_10110,
        19'b10_0_0_000_0_00_00_10_11110,
        19'b01_0_0_000_0_00_00_10_00110,
        19'b01_0_0_000_0_00_00_01_11110,
        19'b11_0_0_000_0_00_00_01_10110,
        19'b11_0_0_000_0_00_00_10_11110,
        19'b00_1_1_100_0_00_00_00_00010,
        19'b00_1_1_010_0_00_00_00_00010,
        19'b00_1_1_001_0_00_00_00_00010,
        19'b00_1_1_000_0_00_00_00_00110,
        19'b00_1_0_111_0_00_00_00_00110,
        19'b00_0_0_000_1_00_00_00_00010,
        19'b00_0_1_111_0_00_00_00_00110,
        19'b00_0_0_000_0_10_10_00_00100,
        19'b00_0_0_000_0_10_00_00_00110,
        19'b00_0_0_000_0_00_10_00_00110,
        19'b00_0_0_000_0_01_01_00_00111,
        19'b00_0_0_000_0_01_00_00_00110,
        19'b00_0_0_000_0_00_01_00_00110,
        19'b10_1_1_100_0_11_11_10_11001
    };

    function automatic string vec_req(int i);
        if (i < 2)  return "R2";
        if (i < 4)  return "R3";
        if (i < 6)  return "R4";
        if (i < 8)  return "R5";
        if (i < 11) return "R7";
        if (i < 13) return "R8";
        if (i < 15) return "R9";
        if (i < 18) return "R10";
        if (i < 21) return "R11";
        return "R5";
    endfunction

    function automatic logic [4:0] outs();
        return {txd_pin, rxd_core, rts_n, tx_permit, rx_discard};
    endfunction

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic apply(input logic [13:0] v);
        {loc_loop_en, rem_loop_en, auto_rts_en, chan_en, tx_busy, rts_manual,
         cts_gate_en, dsr_gate_en, cts_n, dsr_n, txd_core, rxd_pin} = v;
    endtask

    initial begin
        // R1: reset values with inputs that would otherwise move every output
        auto_rts_en = 1; chan_en = 1; tx_busy = 3'b111;
        cts_gate_en = 1; cts_n = 1; txd_core = 1; rxd_pin = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset", outs(), 5'b10110);
        txd_core = 0;
        #0.1;
        chk("R1 reset route", {4'b0, txd_pin}, 5'b00000);
        @(negedge clk);
        apply(14'b0);
        rst_n = 1;
        repeat (4) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i][18:5]);
            repeat (4) @(negedge clk);
            chk(vec_req(i), outs(), VECS[i][4:0]);
        end

        // R6: route switch waits for the edge
        apply(14'b0);
        repeat (2) @(negedge clk);
        loc_loop_en = 1; txd_core = 0;
        #0.1;
        chk("R6 before edge", {4'b0, txd_pin}, 5'b00000);
        @(negedge clk);
        chk("R6 after edge", {4'b0, txd_pin}, 5'b00001);

        // R3: rxd_pin activity ignored in local loop
        txd_core = 1;
        for (int k = 0; k < 4; k++) begin
            rxd_pin = k[0];
            @(negedge clk);
            chk("R3 rxd ignored", {3'b0, txd_pin, rxd_core}, 5'b00011);
        end

        // R4: txd_core activity does not reach the line in remote echo
        loc_loop_en = 0; rem_loop_en = 1; rxd_pin = 0;
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            txd_core = k[0];
            @(negedge clk);
            chk("R4 txd ignored", {4'b0, txd_pin}, 5'b00000);
        end
        rem_loop_en = 0;

        // R12: cts_n to tx_permit takes three edges
        cts_gate_en = 1; cts_n = 0;
        repeat (4) @(negedge clk);
        cts_n = 1;
        repeat (2) @(negedge clk);
        chk("R12 cts after 2 edges", {4'b0, tx_permit}, 5'b00001);
        @(negedge clk);
        chk("R12 cts after 3 edges", {4'b0, tx_permit}, 5'b00000);
        // R12: enable bit takes one edge
        cts_gate_en = 0;
        @(negedge clk);
        chk("R12 enable clear", {4'b0, tx_permit}, 5'b00001);
        cts_gate_en = 1;
        @(negedge clk);
        chk("R12 enable set", {4'b0, tx_permit}, 5'b00000);

        // R12: dsr_n path delay
        dsr_gate_en = 1; dsr_n = 0;
        repeat (4) @(negedge clk);
        dsr_n = 1;
        repeat (2) @(negedge clk);
        chk("R12 dsr after 2 edges", {4'b0, rx_discard}, 5'b00000);
        @(negedge clk);
        chk("R12 dsr after 3 edges", {4'b0, rx_discard}, 5'b00001);

        // R13: character bits keep flowing while CTS is withdrawn
        for (int k = 0; k < 4; k++) begin
            txd_core = ~k[0];
            @(negedge clk);
            chk("R13 bit flows", {3'b0, txd_pin, tx_permit}, {3'b0, ~k[0], 1'b0});
        end

        // R7 / R8: RTS follows occupancy one edge later
        apply(14'b0);
        auto_rts_en = 1; chan_en = 1;
        @(negedge clk);
        tx_busy = 3'b001;
        #0.1;
        chk("R7 before edge", {4'b0, rts_n}, 5'b00001);
        @(negedge clk);
        chk("R7 after edge", {4'b0, rts_n}, 5'b00000);
        tx_busy = 3'b000;
        @(negedge clk);
        chk("R8 drained", {4'b0, rts_n}, 5'b00001);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

endmodule